// File: doc/BRIEF.md
# Parity-Checked Instruction Scratchpad

This block is an on-chip instruction store that protects itself against soft errors by detection only. Each 32-bit word is stored with two extra check bits. One is the parity of the bits in even positions and the other is the parity of the bits in odd positions. Both bits are recomputed on every fetch. A mismatch flags the fetch as bad and raises an interrupt. The interrupt reports the failing block and the main-memory address from which a recovery routine can copy that block back. The scratchpad never repairs a word itself.

The recovery address can come from two places. In static placement it comes from a fixed mirror segment: the segment base plus the byte offset of the block in the scratchpad. In dynamic placement it comes from a per-block table, which is written through a configuration port whenever a block is placed. The recovery routine writes the block back through the normal write port. The block stays marked untrusted until every one of its words has been rewritten. A debug input flips chosen stored data bits without touching the check bits, so that multi-bit upsets can be injected.

Top module: `ispm_top`

## Requirements
- R1: A fetch request returns the stored data word with `fetch_valid_o` high exactly one clock later. With no request, `fetch_valid_o` is low the next cycle.
- R2: Every write stores check bit 0 as the XOR of data bits 0,2,...,30 and check bit 1 as the XOR of bits 1,3,...,31. On a fetch, `fetch_syn_o` bit 0 is set when the even-position group mismatches and bit 1 is set when the odd-position group mismatches. `fetch_err_o` is high when the syndrome is nonzero or the block is untrusted.
- R3: Fetched data is never corrected. `fetch_data_o` returns the stored bits, including any flipped ones.
- R4: When `fetch_err_o` is high and no error is pending, `irq_o` rises on the next clock edge. `err_block_o` then holds the failing word address divided by 16.
- R5: `irq_o`, `err_block_o` and `backup_addr_o` hold until an `err_ack_i` cycle. `irq_o` is low on the edge after the ack. Errors that occur while one is pending are not captured.
- R6: In static mode (`mode_dyn_i`=0), `backup_addr_o` = `static_base_i` + 64 × block.
- R7: In dynamic mode (`mode_dyn_i`=1), `backup_addr_o` is the table entry last written for that block through `map_we_i`.
- R8: Reset marks all blocks untrusted. A captured error marks its block untrusted. Fetches to an untrusted block flag an error until all 16 of its words have been written.
- R9: Single-bit flips, adjacent two-bit flips and three-bit flips are all detected. Two flips in the same position group (for example bits 0 and 2) give a zero syndrome and are not detected.
- R10: During reset, `fetch_valid_o`, `fetch_err_o` and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_dyn_i | input | 1 | 0 = mirror-segment placement, 1 = table placement |
| static_base_i | input | 32 | Base of the mirror segment in main memory |
| fetch_req_i | input | 1 | Fetch request |
| fetch_addr_i | input | 10 | Fetch word address |
| fetch_valid_o | output | 1 | Fetch result valid |
| fetch_data_o | output | 32 | Fetched word |
| fetch_err_o | output | 1 | Fetch flagged bad |
| fetch_syn_o | output | 2 | Per-group parity mismatch |
| wr_en_i | input | 1 | Word write enable |
| wr_addr_i | input | 10 | Write word address |
| wr_data_i | input | 32 | Write data |
| map_we_i | input | 1 | Table entry write |
| map_blk_i | input | 6 | Table entry index |
| map_addr_i | input | 32 | Main-memory source address of the block |
| flip_en_i | input | 1 | Debug bit-flip enable |
| flip_addr_i | input | 10 | Word to corrupt |
| flip_mask_i | input | 32 | Data bits to invert |
| err_ack_i | input | 1 | Acknowledge of the pending error |
| irq_o | output | 1 | Error interrupt |
| err_block_o | output | 6 | Failing block number |
| backup_addr_o | output | 32 | Main-memory address of the block copy |

## Verification
The properties assume that `static_base_i` and `mode_dyn_i` do not change around an error capture. The static-address property only applies when the base was stable across the capturing edge. The stimulus sets the base once, after reset, and changes the mode only while no fetch error is in flight. Writes, flips and fetches never target the same word in the same cycle, and a capture is never made to coincide with a write to the same block. The order of these collisions is therefore never relied on.

// File: rtl/ispm_pkg.sv
package ispm_pkg;
  typedef enum logic {
    BK_STATIC  = 1'b0,
    BK_DYNAMIC = 1'b1
  } bk_mode_e;
endpackage

// File: rtl/ispm_par_enc.sv
// Two-group interleaved parity: bit0 over even positions, bit1 over odd.
module ispm_par_enc #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [1:0]        par_o
);
  localparam int HALF = DATA_W / 2;

  logic [HALF-1:0] ev, od;

  for (genvar g = 0; g < HALF; g++) begin : g_split
    assign ev[g] = data_i[2*g];
    assign od[g] = data_i[2*g+1];
  end

  assign par_o = {^od, ^ev};
endmodule

// File: rtl/ispm_store.sv
module ispm_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  parameter int AW     = 10
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              flip_en_i,
  input  logic [AW-1:0]     flip_addr_i,
  input  logic [DATA_W-1:0] flip_mask_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [1:0]        rd_par_o
);
  localparam int SW = DATA_W + 2;

  logic [SW-1:0] mem_q [DEPTH];
  logic [SW-1:0] rd_q;
  logic [1:0]    wr_par;

  ispm_par_enc #(.DATA_W(DATA_W)) u_wr_enc (
    .data_i (wr_data_i),
    .par_o  (wr_par)
  );

  // flip leaves check bits alone; a write in the same cycle wins
  always_ff @(posedge clk_i) begin
    if (flip_en_i) mem_q[flip_addr_i] <= mem_q[flip_addr_i] ^ {2'b00, flip_mask_i};
    if (wr_en_i)   mem_q[wr_addr_i]   <= {wr_par, wr_data_i};
    if (rd_en_i)   rd_q               <= mem_q[rd_addr_i];
  end

  assign rd_data_o = rd_q[DATA_W-1:0];
  assign rd_par_o  = rd_q[SW-1:DATA_W];
endmodule

// File: rtl/ispm_backup_map.sv
module ispm_backup_map
  import ispm_pkg::*;
#(
  parameter int NUM_BLKS = 64,
  parameter int BW       = 6,
  parameter int MA_W     = 32,
  parameter int BLK_SH   = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  bk_mode_e        mode_i,
  input  logic [MA_W-1:0] static_base_i,
  input  logic            map_we_i,
  input  logic [BW-1:0]   map_blk_i,
  input  logic [MA_W-1:0] map_addr_i,
  input  logic [BW-1:0]   blk_i,
  output logic [MA_W-1:0] addr_o
);
  logic [MA_W-1:0] tbl_q [NUM_BLKS];
  logic [MA_W-1:0] static_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_BLKS; i++) tbl_q[i] <= '0;
    end else if (map_we_i) begin
      tbl_q[map_blk_i] <= map_addr_i;
    end
  end

  assign static_addr = static_base_i + (MA_W'(blk_i) << BLK_SH);

  always_comb begin
    unique case (mode_i)
      BK_DYNAMIC: addr_o = tbl_q[blk_i];
      default:    addr_o = static_addr;
    endcase
  end
endmodule

// File: rtl/ispm_err_ctrl.sv
module ispm_err_ctrl #(
  parameter int NUM_BLKS = 64,
  parameter int BW       = 6,
  parameter int WPB      = 16,
  parameter int OW       = 4,
  parameter int MA_W     = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fetch_req_i,
  input  logic [BW-1:0]   fetch_blk_i,
  input  logic            wr_en_i,
  input  logic [BW-1:0]   wr_blk_i,
  input  logic [OW-1:0]   wr_word_i,
  input  logic            err_i,
  input  logic [BW-1:0]   err_blk_i,
  input  logic [MA_W-1:0] bk_addr_i,
  input  logic            ack_i,
  output logic            blk_ok_o,
  output logic            irq_o,
  output logic [BW-1:0]   err_block_o,
  output logic [MA_W-1:0] backup_addr_o
);
  logic [WPB-1:0]  mask_q [NUM_BLKS];
  logic            pend_q, ok_q, cap;
  logic [BW-1:0]   eblk_q;
  logic [MA_W-1:0] baddr_q;

  assign cap = err_i & ~pend_q;

  // per-block rewrite tracking; a write after a clear in the same cycle keeps its bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_BLKS; i++) mask_q[i] <= '0;
    end else begin
      if (cap)     mask_q[err_blk_i]            <= '0;
      if (wr_en_i) mask_q[wr_blk_i][wr_word_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ok_q <= 1'b0;
    else if (fetch_req_i) ok_q <= &mask_q[fetch_blk_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      eblk_q  <= '0;
      baddr_q <= '0;
    end else if (pend_q) begin
      if (ack_i) pend_q <= 1'b0;
    end else if (err_i) begin
      pend_q  <= 1'b1;
      eblk_q  <= err_blk_i;
      baddr_q <= bk_addr_i;
    end
  end

  assign blk_ok_o      = ok_q;
  assign irq_o         = pend_q;
  assign err_block_o   = eblk_q;
  assign backup_addr_o = baddr_q;
endmodule

// File: rtl/ispm_top.sv
module ispm_top
  import ispm_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MEM_BYTES = 4096,
  parameter int BLK_BYTES = 64,
  parameter int MA_W      = 32,
  localparam int WB       = DATA_W / 8,
  localparam int DEPTH    = MEM_BYTES / WB,
  localparam int WPB      = BLK_BYTES / WB,
  localparam int NUM_BLKS = DEPTH / WPB,
  localparam int AW       = $clog2(DEPTH),
  localparam int OW       = $clog2(WPB),
  localparam int BW       = AW - OW,
  localparam int BLK_SH   = $clog2(BLK_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_dyn_i,
  input  logic [MA_W-1:0]   static_base_i,
  input  logic              fetch_req_i,
  input  logic [AW-1:0]     fetch_addr_i,
  output logic              fetch_valid_o,
  output logic [DATA_W-1:0] fetch_data_o,
  output logic              fetch_err_o,
  output logic [1:0]        fetch_syn_o,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              map_we_i,
  input  logic [BW-1:0]     map_blk_i,
  input  logic [MA_W-1:0]   map_addr_i,
  input  logic              flip_en_i,
  input  logic [AW-1:0]     flip_addr_i,
  input  logic [DATA_W-1:0] flip_mask_i,
  input  logic              err_ack_i,
  output logic              irq_o,
  output logic [BW-1:0]     err_block_o,
  output logic [MA_W-1:0]   backup_addr_o
);
  logic              fval_q;
  logic [BW-1:0]     fblk_q;
  logic [DATA_W-1:0] rd_data;
  logic [1:0]        rd_par, calc_par, syn;
  logic              blk_ok;
  logic [MA_W-1:0]   bk_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fval_q <= 1'b0;
      fblk_q <= '0;
    end else begin
      fval_q <= fetch_req_i;
      if (fetch_req_i) fblk_q <= fetch_addr_i[AW-1:OW];
    end
  end

  ispm_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_i       (clk_i),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .flip_en_i   (flip_en_i),
    .flip_addr_i (flip_addr_i),
    .flip_mask_i (flip_mask_i),
    .rd_en_i     (fetch_req_i),
    .rd_addr_i   (fetch_addr_i),
    .rd_data_o   (rd_data),
    .rd_par_o    (rd_par)
  );

  ispm_par_enc #(.DATA_W(DATA_W)) u_rd_enc (
    .data_i (rd_data),
    .par_o  (calc_par)
  );

  assign syn           = calc_par ^ rd_par;
  assign fetch_valid_o = fval_q;
  assign fetch_data_o  = rd_data;
  assign fetch_syn_o   = fval_q ? syn : 2'b00;
  assign fetch_err_o   = fval_q & ((|syn) | ~blk_ok);

  ispm_backup_map #(.NUM_BLKS(NUM_BLKS), .BW(BW), .MA_W(MA_W), .BLK_SH(BLK_SH)) u_map (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_i        (bk_mode_e'(mode_dyn_i)),
    .static_base_i (static_base_i),
    .map_we_i      (map_we_i),
    .map_blk_i     (map_blk_i),
    .map_addr_i    (map_addr_i),
    .blk_i         (fblk_q),
    .addr_o        (bk_addr)
  );

  ispm_err_ctrl #(.NUM_BLKS(NUM_BLKS), .BW(BW), .WPB(WPB), .OW(OW), .MA_W(MA_W)) u_err (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fetch_req_i   (fetch_req_i),
    .fetch_blk_i   (fetch_addr_i[AW-1:OW]),
    .wr_en_i       (wr_en_i),
    .wr_blk_i      (wr_addr_i[AW-1:OW]),
    .wr_word_i     (wr_addr_i[OW-1:0]),
    .err_i         (fetch_err_o),
    .err_blk_i     (fblk_q),
    .bk_addr_i     (bk_addr),
    .ack_i         (err_ack_i),
    .blk_ok_o      (blk_ok),
    .irq_o         (irq_o),
    .err_block_o   (err_block_o),
    .backup_addr_o (backup_addr_o)
  );
endmodule

// File: rtl/ispm_checker.sv
module ispm_checker #(
  parameter int BW     = 6,
  parameter int MA_W   = 32,
  parameter int BLK_SH = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mode_dyn_i,
  input logic [MA_W-1:0] static_base_i,
  input logic            fetch_req_i,
  input logic            fetch_valid_o,
  input logic            fetch_err_o,
  input logic [1:0]      fetch_syn_o,
  input logic            err_ack_i,
  input logic            irq_o,
  input logic [BW-1:0]   err_block_o,
  input logic [MA_W-1:0] backup_addr_o
);
  assert_fetch_lat_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_i |=> fetch_valid_o);

  assert_fetch_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_req_i |=> !fetch_valid_o);

  assert_syn_flags_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_o && fetch_syn_o != 2'b00) |-> fetch_err_o);

  assert_irq_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(fetch_err_o));

  assert_irq_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !err_ack_i) |=> (irq_o && $stable(err_block_o) && $stable(backup_addr_o)));

  assert_ack_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && err_ack_i) |=> !irq_o);

  assert_static_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_o) && !$past(mode_dyn_i) && $stable(static_base_i)) |->
      backup_addr_o == static_base_i + (MA_W'(err_block_o) << BLK_SH));
endmodule

bind ispm_top ispm_checker #(.BW(BW), .MA_W(MA_W), .BLK_SH(BLK_SH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_dyn_i    (mode_dyn_i),
  .static_base_i (static_base_i),
  .fetch_req_i   (fetch_req_i),
  .fetch_valid_o (fetch_valid_o),
  .fetch_err_o   (fetch_err_o),
  .fetch_syn_o   (fetch_syn_o),
  .err_ack_i     (err_ack_i),
  .irq_o         (irq_o),
  .err_block_o   (err_block_o),
  .backup_addr_o (backup_addr_o)
);

// File: tb/ispm_top_tb_top.sv
module ispm_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_dyn = 1'b0;
  logic [31:0] base = 32'h1000_0000;
  logic        f_req = 1'b0;
  logic [9:0]  f_addr = '0;
  logic        wr_en = 1'b0;
  logic [9:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        map_we = 1'b0;
  logic [5:0]  map_blk = '0;
  logic [31:0] map_addr = '0;
  logic        flip_en = 1'b0;
  logic [9:0]  flip_addr = '0;
  logic [31:0] flip_mask = '0;
  logic        ack = 1'b0;

  logic        f_val, f_err, irq;
  logic [31:0] f_data, baddr;
  logic [1:0]  f_syn;
  logic [5:0]  eblk;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ispm_top #(.DATA_W(32), .MEM_BYTES(4096), .BLK_BYTES(64), .MA_W(32)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_dyn_i(mode_dyn), .static_base_i(base),
    .fetch_req_i(f_req), .fetch_addr_i(f_addr), .fetch_valid_o(f_val),
    .fetch_data_o(f_data), .fetch_err_o(f_err), .fetch_syn_o(f_syn),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .map_we_i(map_we), .map_blk_i(map_blk), .map_addr_i(map_addr),
    .flip_en_i(flip_en), .flip_addr_i(flip_addr), .flip_mask_i(flip_mask),
    .err_ack_i(ack), .irq_o(irq), .err_block_o(eblk), .backup_addr_o(baddr)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_dat [1024];
  logic [1:0]  m_par [1024];
  bit   [15:0] m_wr  [64];
  logic [31:0] m_tbl [64];
  logic        e_val = 1'b0, e_err = 1'b0, e_irq = 1'b0;
  logic [31:0] e_data = '0, e_baddr = '0;
  logic [1:0]  e_syn = '0;
  logic [5:0]  e_fblk = '0, e_eblk = '0;
  logic        o_err;
  logic [5:0]  o_fblk;

  function automatic logic [1:0] ref_par(input logic [31:0] d);
    logic [1:0] p = 2'b00;
    for (int i = 0; i < 32; i++) begin
      if (i % 2 == 0) p[0] = p[0] ^ d[i];
      else            p[1] = p[1] ^ d[i];
    end
    return p;
  endfunction

  function automatic logic [31:0] pat(input int i);
    return (i * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_val = 1'b0; e_err = 1'b0; e_irq = 1'b0; e_syn = '0;
      for (int b = 0; b < 64; b++) begin m_wr[b] = '0; m_tbl[b] = '0; end
    end else begin
      o_err  = e_err;
      o_fblk = e_fblk;
      if (f_req) begin
        e_val  = 1'b1;
        e_data = m_dat[f_addr];
        e_syn  = ref_par(m_dat[f_addr]) ^ m_par[f_addr];
        e_fblk = f_addr / 16;
        e_err  = (e_syn != 2'b00) || (m_wr[f_addr / 16] != 16'hFFFF);
      end else begin
        e_val = 1'b0; e_err = 1'b0; e_syn = 2'b00;
      end
      if (e_irq) begin
        if (ack) e_irq = 1'b0;
      end else if (o_err) begin
        e_irq   = 1'b1;
        e_eblk  = o_fblk;
        e_baddr = mode_dyn ? m_tbl[o_fblk] : base + 32'(o_fblk) * 64;
        m_wr[o_fblk] = '0;
      end
      if (flip_en) m_dat[flip_addr] = m_dat[flip_addr] ^ flip_mask;
      if (wr_en) begin
        m_dat[wr_addr] = wr_data;
        m_par[wr_addr] = ref_par(wr_data);
        m_wr[wr_addr / 16][wr_addr % 16] = 1'b1;
      end
      if (map_we) m_tbl[map_blk] = map_addr;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1", "valid", 32'(f_val), 32'(e_val));
      if (e_val) begin
        chk("R3", "data", f_data, e_data);
        chk("R2", "syn", 32'(f_syn), 32'(e_syn));
        chk("R8", "err", 32'(f_err), 32'(e_err));
      end
      chk("R5", "irq", 32'(irq), 32'(e_irq));
      if (e_irq) begin
        chk("R4", "block", 32'(eblk), 32'(e_eblk));
        chk(mode_dyn ? "R7" : "R6", "backup", baddr, e_baddr);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = 10'(a); wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic fetch(input int a);
    f_req = 1'b1; f_addr = 10'(a);
    @(negedge clk); f_req = 1'b0;
  endtask

  task automatic flip(input int a, input logic [31:0] m);
    flip_en = 1'b1; flip_addr = 10'(a); flip_mask = m;
    @(negedge clk); flip_en = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reload(input int b);
    for (int w = 0; w < 16; w++) wr(b * 16 + w, pat(b * 16 + w));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "reset valid", 32'(f_val), 32'h0);
    chk("R10", "reset err", 32'(f_err), 32'h0);
    chk("R10", "reset irq", 32'(irq), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int b = 0; b < 64; b++) begin
      map_we = 1'b1; map_blk = 6'(b); map_addr = 32'h8000_0000 + b * 32'h400;
      @(negedge clk);
    end
    map_we = 1'b0;

    // R8: before loading, a fetch sees an untrusted block
    fetch(3);
    chk("R8", "unloaded err", 32'(f_err), 32'h1);
    idle(1);
    do_ack();
    chk("R5", "ack clears", 32'(irq), 32'h0);

    for (int i = 0; i < 1024; i++) wr(i, pat(i));

    fetch(5);
    chk("R1", "clean data", f_data, pat(5));
    chk("R2", "clean err", 32'(f_err), 32'h0);
    fetch(1023);
    chk("R1", "last word", f_data, pat(1023));

    // single even-group flip in block 2
    flip(37, 32'h10);
    fetch(37);
    chk("R2", "even syn", 32'(f_syn), 32'h1);
    chk("R3", "no correction", f_data, pat(37) ^ 32'h10);
    idle(1);
    chk("R4", "irq up", 32'(irq), 32'h1);
    chk("R4", "block 2", 32'(eblk), 32'h2);
    chk("R6", "static addr", baddr, 32'h1000_0080);

    // error while pending is not captured
    flip(100, 32'h20);
    fetch(100);
    chk("R2", "odd syn", 32'(f_syn), 32'h2);
    idle(2);
    chk("R5", "block held", 32'(eblk), 32'h2);

    fetch(40);
    chk("R8", "invalid block err", 32'(f_err), 32'h1);
    chk("R8", "invalid block syn", 32'(f_syn), 32'h0);
    for (int w = 32; w < 47; w++) wr(w, pat(w));
    fetch(40);
    chk("R8", "partial reload err", 32'(f_err), 32'h1);
    wr(47, pat(47));
    fetch(40);
    chk("R8", "full reload ok", 32'(f_err), 32'h0);
    do_ack();
    chk("R5", "irq dropped", 32'(irq), 32'h0);

    // dynamic placement
    mode_dyn = 1'b1;
    idle(1);
    fetch(100);
    idle(1);
    chk("R7", "dyn block", 32'(eblk), 32'h6);
    chk("R7", "dyn addr", baddr, 32'h8000_1800);
    do_ack();
    reload(6);

    // R9: same-group double is silent, adjacent double is caught
    flip(200, 32'h5);
    fetch(200);
    chk("R9", "same group miss", 32'(f_err), 32'h0);
    chk("R3", "corrupt data", f_data, pat(200) ^ 32'h5);
    flip(200, 32'h6);
    fetch(200);
    chk("R9", "adjacent syn", 32'(f_syn), 32'h3);
    idle(1);
    do_ack();
    reload(12);
    fetch(201);
    chk("R9", "restored", 32'(f_err), 32'h0);
    flip(201, 32'h38);
    fetch(201);
    chk("R9", "triple syn", 32'(f_syn), 32'h1);
    chk("R9", "triple err", 32'(f_err), 32'h1);
    idle(1);
    chk("R7", "dyn block 12", 32'(eblk), 32'd12);
    do_ack();
    reload(12);
    idle(3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule